// File: doc/BRIEF.md
# Double-Buffered NCO Frequency Register Bank

This block holds two 32-bit frequency words, A and B, that a host fills one byte at a time through a narrow write port. The host writes into the inactive word at leisure. It can then move either word into the active increment register of a phase accumulator. The choice of word comes from a select pin, and the move is triggered by a falling edge on an active-low load input.

The host port is synchronous to the block clock. A write is taken on the clock where the strobe is first seen high. The target byte comes from a 4-bit address: slots 0 to 3 are bytes 0 to 3 of word A and slots 4 to 7 are bytes 0 to 3 of word B, least significant byte first. Slots 8 to 15 are not used.

Load timing is fixed:
- The clock edge that first sees the load input low, after it was high, is the command edge.
- The select pin and the selected word are sampled on the next edge.
- The word becomes active one edge after that.

The accumulator adds the active word on every clock and wraps modulo 2^32. Its value leaves the block through a delay line, so a new frequency shows at the output exactly `LATENCY` edges after the command edge (default 19).

Top module: `nco_freq_bank`

## Requirements
- R1: Reset is asynchronous and active low, and its release is synchronised. Both words, the active word and the accumulator clear to zero, and `phase_out` reads 0 until a non-zero word is loaded.
- R2: On the clock where `wr_stb` is first seen high, after being seen low, `wr_data` is written into the byte chosen by `wr_addr`. Value 0 to 3 selects word A byte 0 to 3, and value 4 to 7 selects word B byte 0 to 3, where byte n is bits 8n+7 to 8n. A strobe held high writes once only.
- R3: Bytes can be written in any order. A byte that is not written keeps its value.
- R4: A write with `wr_addr` 8 to 15 changes neither word.
- R5: `buf_sel` is sampled one edge after the command edge. At 1 it selects word A and at 0 it selects word B. Its value on the command edge itself does not matter.
- R6: The sampled word becomes the active increment two edges after the command edge. Keeping `load_n` low, or raising it, starts no further load.
- R7: On each clock the accumulator adds the active word, modulo 2^32.
- R8: Let E be the command edge and let p(n) be the value of `phase_out` after edge n. Then p(E+LATENCY) - p(E+LATENCY-1) is the new word, and every earlier step still uses the old word.
- R9: Writes to a word after it has been sampled do not change the active increment until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Byte write strobe, acts on its rising edge |
| wr_addr | input | 4 | Byte slot: 0-3 word A, 4-7 word B, 8-15 unused |
| wr_data | input | 8 | Byte to write |
| buf_sel | input | 1 | 1 selects word A, 0 selects word B |
| load_n | input | 1 | Active-low load, acts on its falling edge |
| phase_out | output | 32 | Delayed phase accumulator value |

## Verification
The only visible result of a write is the step of `phase_out` after a later load. The bench therefore computes that step, p(n) - p(n-1), on every falling clock edge. After lowering `load_n`, it expects the old step for the first `LATENCY` samples and the new word on sample `LATENCY`+1. It changes `buf_sel` between the command edge and the sampling edge, so the selection must come from the second edge. Writes made after sampling, a long low load and a rising load are each followed by step checks before the next load.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    WORD_B = 1'b0,
    WORD_A = 1'b1
  } word_sel_e;
endpackage

// File: rtl/nco_edge_det.sv
// One-clock pulse on a chosen edge of a synchronous input. Reset leaves the
// history at the active level, so a level already present at reset release
// does not count as an edge.
module nco_edge_det #(
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic pulse
);
  logic hist_q, hist_d;

  always_comb hist_d = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= RISE;
    else        hist_q <= hist_d;
  end

  generate
    if (RISE) begin : g_rise
      assign pulse = din & ~hist_q;
    end else begin : g_fall
      assign pulse = ~din & hist_q;
    end
  endgenerate
endmodule

// File: rtl/nco_word_bank.sv
// Two byte-addressed frequency words and the select mux.
module nco_word_bank
  import nco_pkg::*;
#(
  parameter int FW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          sel,
  output logic [FW-1:0] word_a,
  output logic [FW-1:0] word_b,
  output logic [FW-1:0] mux_word
);
  localparam int NB = FW / BYTE_W;

  logic [FW-1:0] words [2];

  for (genvar gw = 0; gw < 2; gw++) begin : g_word
    for (genvar gb = 0; gb < NB; gb++) begin : g_byte
      logic [BYTE_W-1:0] byte_q, byte_d;
      logic              hit;

      assign hit = wr_en && (wr_addr == AW'(gw * NB + gb));

      always_comb begin
        byte_d = byte_q;
        if (hit) byte_d = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byte_q <= '0;
        else        byte_q <= byte_d;
      end

      assign words[gw][gb*BYTE_W +: BYTE_W] = byte_q;
    end
  end

  assign word_a   = words[0];
  assign word_b   = words[1];
  assign mux_word = (word_sel_e'(sel) == WORD_A) ? word_a : word_b;
endmodule

// File: rtl/nco_load_ctrl.sv
// Command edge -> sample edge -> transfer edge.
module nco_load_ctrl #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  logic [FW-1:0] mux_word,
  output logic          cap_q,
  output logic          xfer_q,
  output logic [FW-1:0] stage_q,
  output logic [FW-1:0] active_q
);
  logic          cap_d, xfer_d;
  logic [FW-1:0] stage_d, active_d;

  always_comb begin
    cap_d    = fall;
    xfer_d   = cap_q;
    stage_d  = stage_q;
    active_d = active_q;
    if (cap_q)  stage_d  = mux_word;
    if (xfer_q) active_d = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q    <= 1'b0;
      xfer_q   <= 1'b0;
      stage_q  <= '0;
      active_q <= '0;
    end else begin
      cap_q    <= cap_d;
      xfer_q   <= xfer_d;
      stage_q  <= stage_d;
      active_q <= active_d;
    end
  end
endmodule

// File: rtl/nco_phase_pipe.sv
// Accumulator followed by a DEPTH-stage delay line.
module nco_phase_pipe #(
  parameter int FW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] incr,
  output logic [FW-1:0] acc_q,
  output logic [FW-1:0] phase_out
);
  logic [FW-1:0] acc_d;

  always_comb acc_d = acc_q + incr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  generate
    if (DEPTH == 0) begin : g_direct
      assign phase_out = acc_q;
    end else begin : g_delay
      logic [FW-1:0] dly_q [DEPTH];
      logic [FW-1:0] dly_d [DEPTH];

      always_comb begin
        dly_d[0] = acc_q;
        for (int i = 1; i < DEPTH; i++) dly_d[i] = dly_q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) dly_q[i] <= '0;
        end else begin
          for (int i = 0; i < DEPTH; i++) dly_q[i] <= dly_d[i];
        end
      end

      assign phase_out = dly_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/nco_freq_bank.sv
module nco_freq_bank #(
  parameter int FW      = 32,
  parameter int AW      = 4,
  parameter int LATENCY = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          buf_sel,
  input  logic          load_n,
  output logic [FW-1:0] phase_out
);
  // Three register stages sit in front of the delay line: sample, transfer, accumulate.
  localparam int OUT_DEPTH = LATENCY - 3;

  logic [1:0]    rst_sync_q;
  logic          rst_s;
  logic          wr_rise, fall;
  logic          cap_q, xfer_q;
  logic [FW-1:0] word_a, word_b, mux_word, stage_q, active_q, acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  nco_edge_det #(.RISE(1'b1)) u_wr_edge (
    .clk(clk), .rst_n(rst_s), .din(wr_stb), .pulse(wr_rise));

  nco_edge_det #(.RISE(1'b0)) u_ld_edge (
    .clk(clk), .rst_n(rst_s), .din(load_n), .pulse(fall));

  nco_word_bank #(.FW(FW), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_rise), .wr_addr(wr_addr),
    .wr_data(wr_data), .sel(buf_sel), .word_a(word_a), .word_b(word_b),
    .mux_word(mux_word));

  nco_load_ctrl #(.FW(FW)) u_load (
    .clk(clk), .rst_n(rst_s), .fall(fall), .mux_word(mux_word),
    .cap_q(cap_q), .xfer_q(xfer_q), .stage_q(stage_q), .active_q(active_q));

  nco_phase_pipe #(.FW(FW), .DEPTH(OUT_DEPTH)) u_pipe (
    .clk(clk), .rst_n(rst_s), .incr(active_q), .acc_q(acc_q),
    .phase_out(phase_out));
endmodule

// File: rtl/nco_freq_bank_chk.sv
module nco_freq_bank_chk #(
  parameter int FW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_s,
  input logic          wr_rise,
  input logic [AW-1:0] wr_addr,
  input logic          cap_q,
  input logic          xfer_q,
  input logic [FW-1:0] word_a,
  input logic [FW-1:0] word_b,
  input logic [FW-1:0] mux_word,
  input logic [FW-1:0] stage_q,
  input logic [FW-1:0] active_q,
  input logic [FW-1:0] acc_q,
  input logic [FW-1:0] phase_out
);
  p_reset_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_s) |-> (phase_out == '0));

  p_buf_hold_r2: assert property (@(posedge clk) disable iff (!rst_s)
    !wr_rise |=> ($stable(word_a) && $stable(word_b)));

  p_addr_ignore_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_rise && wr_addr[AW-1]) |=> ($stable(word_a) && $stable(word_b)));

  p_sample_r5: assert property (@(posedge clk) disable iff (!rst_s)
    cap_q |=> (stage_q == $past(mux_word)));

  p_transfer_r6: assert property (@(posedge clk) disable iff (!rst_s)
    xfer_q |=> (active_q == $past(stage_q)));

  p_acc_step_r7: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> (acc_q == $past(acc_q) + $past(active_q)));

  p_active_hold_r9: assert property (@(posedge clk) disable iff (!rst_s)
    !xfer_q |=> $stable(active_q));
endmodule

bind nco_freq_bank nco_freq_bank_chk #(.FW(FW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_s(rst_s), .wr_rise(wr_rise),
  .wr_addr(wr_addr), .cap_q(cap_q), .xfer_q(xfer_q), .word_a(word_a),
  .word_b(word_b), .mux_word(mux_word), .stage_q(stage_q),
  .active_q(active_q), .acc_q(acc_q), .phase_out(phase_out));

// File: tb/test_nco_freq_bank.sv
`timescale 1ns/1ps
module test_nco_freq_bank;
  localparam int LAT = 19;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_stb;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        buf_sel;
  logic        load_n;
  logic [31:0] phase_out;

  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;
  logic [31:0] cur = '0, last = '0, inc = '0;
  logic [31:0] exp_inc = '0;

  always #2.5 clk = ~clk;

  nco_freq_bank #(.LATENCY(LAT)) i_nco_freq_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .buf_sel(buf_sel), .load_n(load_n),
    .phase_out(phase_out));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    last = cur;
    cur  = phase_out;
    inc  = cur - last;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_stb = 1'b1;
    cyc();
    wr_stb = 1'b0;
    cyc();
  endtask

  // Step must stay at the expected value for n samples.
  task automatic hold(input int n, input string req);
    bit ok = 1'b1;
    logic [31:0] bad = '0;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (inc !== exp_inc && ok) begin ok = 1'b0; bad = inc; end
    end
    chk(ok, req, bad, exp_inc);
  endtask

  // s0 drives buf_sel on the command edge, s1 on the sampling edge.
  task automatic do_load(input logic s0, input logic s1,
                         input logic [31:0] nw, input string req);
    bit ok = 1'b1;
    logic [31:0] bad = '0;
    buf_sel = s0; load_n = 1'b0;
    cyc();
    buf_sel = s1;
    if (inc !== exp_inc) begin ok = 1'b0; bad = inc; end
    for (int k = 2; k <= LAT; k++) begin
      cyc();
      if (inc !== exp_inc && ok) begin ok = 1'b0; bad = inc; end
    end
    chk(ok, "R8 old step before latency", bad, exp_inc);
    cyc();
    chk(inc === nw, req, inc, nw);
    exp_inc = nw;
    load_n = 1'b1;
    cyc();
    chk(inc === nw, "R8 new step held", inc, nw);
  endtask

  initial begin
    rst_n = 1'b0; wr_stb = 1'b0; wr_addr = '0; wr_data = '0;
    buf_sel = 1'b1; load_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1: output stays zero after reset, even after a load of zeroed words
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 8; i++) begin
        cyc();
        if (phase_out !== '0) ok = 1'b0;
      end
      chk(ok, "R1 reset output zero", phase_out, 32'h0);
    end
    do_load(1'b1, 1'b1, 32'h0, "R1 cleared word A");
    chk(phase_out === '0, "R1 output zero after loading cleared word", phase_out, 32'h0);

    // R2 sweep over every slot, each load checked for value and buffer choice
    for (int s = 0; s < 8; s++) begin
      logic [31:0] w;
      for (int a = 0; a < 8; a++) wr(4'(a), 8'h00);
      wr(4'(s), 8'(8'h80 + s));
      w = 32'(8'h80 + s) << (8 * (s % 4));
      do_load(s < 4, s < 4, w, "R2 slot sweep byte placement");
    end

    // R3: out-of-order writes, first absolute check from a known phase
    wr(4'd3, 8'h01); wr(4'd1, 8'h03); wr(4'd0, 8'h04); wr(4'd2, 8'h02);
    do_load(1'b0, 1'b1, 32'h01020304, "R3 any write order");

    // R5: command edge says A, sampling edge says B
    wr(4'd7, 8'h10); wr(4'd4, 8'h00); wr(4'd5, 8'h00); wr(4'd6, 8'h00);
    wr(4'd1, 8'hAA);
    do_load(1'b1, 1'b0, 32'h10000000, "R5 select sampled after command edge");
    do_load(1'b0, 1'b1, 32'h0102AA04, "R3 unwritten bytes kept");

    // R4: unused slots
    for (int a = 8; a < 16; a++) wr(4'(a), 8'hFF);
    // R2: strobe held high writes once
    wr_addr = 4'd0; wr_data = 8'h55; wr_stb = 1'b1;
    cyc();
    wr_data = 8'h66;
    cyc(); cyc();
    wr_stb = 1'b0;
    cyc();
    do_load(1'b0, 1'b1, 32'h0102AA55, "R4 unused slots ignored and R2 single write");
    do_load(1'b1, 1'b0, 32'h10000000, "R4 word B untouched by unused slots");

    // R9: writes after sampling do not reach the active word
    do_load(1'b0, 1'b1, 32'h0102AA55, "R9 reload A");
    wr(4'd2, 8'h77);
    hold(6, "R9 active word unchanged by later write");

    // R6: held-low load and its rising edge start nothing
    buf_sel = 1'b1; load_n = 1'b0;
    repeat (LAT + 2) cyc();
    chk(inc === 32'h0177AA55, "R6 first load of held-low command", inc, 32'h0177AA55);
    exp_inc = 32'h0177AA55;
    wr(4'd2, 8'h11); buf_sel = 1'b0;
    hold(40, "R6 no reload while load held low");
    load_n = 1'b1;
    hold(LAT + 4, "R6 rising load edge ignored");

    // R7: wrap of the accumulator
    wr(4'd4, 8'h00); wr(4'd5, 8'h00); wr(4'd6, 8'h00); wr(4'd7, 8'hC0);
    do_load(1'b1, 1'b0, 32'hC0000000, "R7 large step");
    begin
      int wraps = 0;
      bit ok = 1'b1;
      for (int i = 0; i < 8; i++) begin
        cyc();
        if (cur < last) wraps++;
        if (cur !== last + 32'hC0000000) ok = 1'b0;
      end
      chk(ok, "R7 modulo step", inc, 32'hC0000000);
      chk(wraps > 0, "R7 wrap seen", 32'(wraps), 32'h1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule